// File: doc/BRIEF.md
# Address aperture classifier

This block keeps the four window registers that the boot sequencer programs: the base of the memory-mapped register window, the DRAM base, the DRAM limit, and the cacheable limit. Every processor address presented on the request input is sorted into one of four classes: register space, cacheable DRAM, uncacheable DRAM, or unmapped. For a register-space address the block also returns the byte offset inside the 2 MB register window.

The window registers are loaded through a single-cycle write port. The write address is a full processor address, and it is decoded against the register window as it stands at that moment. A write that moves the register window therefore changes how every later write is decoded. The block watches the programmed DRAM values continuously and raises a configuration-error flag while they break the granularity, ordering or alignment rules.

Classification is combinational from the request address and the stored registers. A register write changes the stored value on the clock edge that samples it.

Top module: `aperture_classifier`

## Requirements
- R1: Synchronous active-high reset sets the register-window base to 0xEFE00000, so the window base register sits at address 0xEFF00400. Reset clears the DRAM base, DRAM limit and cacheable limit to zero, which leaves no address classified as DRAM and `cfg_err` low.
- R2: An address inside the 2 MB register window (from the window base up to the window base plus 0x1FFFFF) gives `hit_class` 2'b01, and `reg_offset` equals the address minus the window base. For any other class, `reg_offset` is zero.
- R3: A write with `wr_en` high whose address lies at window offset 0x100000, 0x100004, 0x100008 or 0x100400 loads, on the next rising edge, the DRAM base, the DRAM limit, the cacheable limit or the window base respectively. A write with `wr_en` low, or a write to any other address, changes no register.
- R4: A write to the window base stores only bits 31:21 of the data and clears bits 20:0. The moved window decodes every following write and classification.
- R5: An address that is at least the DRAM base, below the DRAM limit and outside the register window gives 2'b10 (cacheable) when it is also below the cacheable limit, and 2'b11 (uncacheable) otherwise.
- R6: Where the register window overlaps the DRAM window, the register class 2'b01 wins.
- R7: An address in neither window gives `hit_class` 2'b00.
- R8: `cfg_err` is high while bits 15:0 of the DRAM limit or of the cacheable limit are nonzero, that is, while either value is not a multiple of 64 KB.
- R9: `cfg_err` is high while the cacheable limit is greater than the DRAM limit.
- R10: While the DRAM limit is above the DRAM base, `cfg_err` is high if the DRAM base is not a multiple of the window size (limit minus base) rounded up to a power of two. For example, a 6 MB window based at 4 MB is flagged, and the same window based at 8 MB is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 32 | Processor address of the register write |
| wr_data | input | 32 | Value to write |
| req_addr | input | 32 | Address to classify |
| hit_class | output | 2 | 00 unmapped, 01 register, 10 cacheable DRAM, 11 uncacheable DRAM |
| reg_offset | output | 21 | Offset inside the register window, zero when not a register hit |
| cfg_err | output | 1 | Programmed DRAM values break a rule |

## Verification
The class and the offset for a request address are due in the same cycle the address is applied. The effect of a register write, on both the classification and `cfg_err`, is due in the cycle after the edge that sampled the write. The bench drives all inputs on the falling edge and compares the outputs against its model 1 ns later. It applies each write to the model only after the following rising edge, so every comparison lines up with the cycle in which the design's registers change. The bench also probes addresses on both sides of every boundary and returns to a write through an old window address to confirm that the write is ignored.

// File: rtl/apc_pkg.sv
package apc_pkg;

  typedef enum logic [1:0] {
    CLS_NONE    = 2'b00,
    CLS_REG     = 2'b01,
    CLS_CACHE   = 2'b10,
    CLS_UNCACHE = 2'b11
  } apc_class_e;

  // Offsets of the window registers inside the register window
  localparam logic [31:0] OFS_DRAM_REGS = 32'h0010_0000; // base, limit, cacheable limit at +0,+4,+8
  localparam logic [31:0] OFS_WIN_BASE  = 32'h0010_0400;
  localparam int unsigned N_DRAM_REGS   = 3;

endpackage

// File: rtl/apc_regfile.sv
module apc_regfile
  import apc_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter int unsigned WB       = 21,
  parameter logic [AW-1:0] WIN_RST = 32'hEFE0_0000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [AW-1:0] wr_data,
  output logic [AW-1:0] win_base,
  output logic [AW-1:0] dram_base,
  output logic [AW-1:0] dram_lim,
  output logic [AW-1:0] cache_lim
);

  localparam int unsigned HI_W = AW - WB;

  logic [AW-1:0] wr_rel;
  logic [AW-1:0] dram_q [N_DRAM_REGS];

  // offset relative to the current window; decoded each cycle against the live base
  assign wr_rel = wr_addr - win_base;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_base <= WIN_RST;
    end else if (wr_en && wr_rel == AW'(OFS_WIN_BASE)) begin
      win_base <= {wr_data[AW-1:WB], {WB{1'b0}}};
    end
  end

  for (genvar g = 0; g < N_DRAM_REGS; g++) begin : g_dram
    localparam logic [AW-1:0] MY_OFS = AW'(OFS_DRAM_REGS) + AW'(4 * g);
    always_ff @(posedge clk) begin
      if (rst) begin
        dram_q[g] <= '0;
      end else if (wr_en && wr_rel == MY_OFS) begin
        dram_q[g] <= wr_data;
      end
    end
  end

  assign dram_base = dram_q[0];
  assign dram_lim  = dram_q[1];
  assign cache_lim = dram_q[2];

  logic [HI_W-1:0] unused_hi;
  assign unused_hi = '0;

endmodule

// File: rtl/apc_classify.sv
module apc_classify
  import apc_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned WB = 21
) (
  input  logic [AW-1:0] req_addr,
  input  logic [AW-1:0] win_base,
  input  logic [AW-1:0] dram_base,
  input  logic [AW-1:0] dram_lim,
  input  logic [AW-1:0] cache_lim,
  output apc_class_e    hit_class,
  output logic [WB-1:0] reg_offset
);

  localparam logic [AW-1:0] WIN_SIZE = AW'(1) << WB;

  logic [AW-1:0] rel;
  logic          in_win;
  logic          in_dram;
  logic          in_cache;

  assign rel      = req_addr - win_base;
  assign in_win   = rel < WIN_SIZE;
  assign in_dram  = (req_addr >= dram_base) && (req_addr < dram_lim);
  assign in_cache = req_addr < cache_lim;

  always_comb begin
    hit_class  = CLS_NONE;
    reg_offset = '0;
    if (in_win) begin
      hit_class  = CLS_REG;
      reg_offset = rel[WB-1:0];
    end else if (in_dram) begin
      hit_class = in_cache ? CLS_CACHE : CLS_UNCACHE;
    end
  end

endmodule

// File: rtl/apc_cfgcheck.sv
module apc_cfgcheck #(
  parameter int unsigned AW        = 32,
  parameter int unsigned GRAN_BITS = 16
) (
  input  logic [AW-1:0] dram_base,
  input  logic [AW-1:0] dram_lim,
  input  logic [AW-1:0] cache_lim,
  output logic          cfg_err
);

  logic [AW-1:0] span_m1;
  logic [AW-1:0] align_mask;
  logic          gran_bad;
  logic          order_bad;
  logic          base_bad;

  assign span_m1 = dram_lim - dram_base - AW'(1);

  // smear the top set bit downwards: mask of the power-of-two size minus one
  always_comb begin
    align_mask = span_m1;
    for (int i = AW - 2; i >= 0; i--) begin
      align_mask[i] = align_mask[i] | align_mask[i+1];
    end
  end

  assign gran_bad  = (|dram_lim[GRAN_BITS-1:0]) || (|cache_lim[GRAN_BITS-1:0]);
  assign order_bad = cache_lim > dram_lim;
  assign base_bad  = (dram_lim > dram_base) && (|(dram_base & align_mask));
  assign cfg_err   = gran_bad || order_bad || base_bad;

endmodule

// File: rtl/aperture_classifier.sv
module aperture_classifier
  import apc_pkg::*;
#(
  parameter int unsigned     ADDR_W     = 32,
  parameter int unsigned     WIN_BITS   = 21,
  parameter int unsigned     GRAN_BITS  = 16,
  parameter logic [ADDR_W-1:0] MMIO_RESET = 32'hEFE0_0000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [ADDR_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]   req_addr,
  output logic [1:0]          hit_class,
  output logic [WIN_BITS-1:0] reg_offset,
  output logic                cfg_err
);

  logic [ADDR_W-1:0] win_base;
  logic [ADDR_W-1:0] dram_base;
  logic [ADDR_W-1:0] dram_lim;
  logic [ADDR_W-1:0] cache_lim;
  apc_class_e        cls;

  apc_regfile #(.AW(ADDR_W), .WB(WIN_BITS), .WIN_RST(MMIO_RESET)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .win_base  (win_base),
    .dram_base (dram_base),
    .dram_lim  (dram_lim),
    .cache_lim (cache_lim)
  );

  apc_classify #(.AW(ADDR_W), .WB(WIN_BITS)) u_cls (
    .req_addr   (req_addr),
    .win_base   (win_base),
    .dram_base  (dram_base),
    .dram_lim   (dram_lim),
    .cache_lim  (cache_lim),
    .hit_class  (cls),
    .reg_offset (reg_offset)
  );

  apc_cfgcheck #(.AW(ADDR_W), .GRAN_BITS(GRAN_BITS)) u_chk_cfg (
    .dram_base (dram_base),
    .dram_lim  (dram_lim),
    .cache_lim (cache_lim),
    .cfg_err   (cfg_err)
  );

  assign hit_class = cls;

endmodule

// File: rtl/apc_checker.sv
module apc_checker #(
  parameter int unsigned     AW      = 32,
  parameter logic [AW-1:0]   WIN_RST = 32'hEFE0_0000
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [AW-1:0] wr_data,
  input logic [AW-1:0] req_addr,
  input logic [1:0]    hit_class,
  input logic          cfg_err,
  input logic [AW-1:0] win_base,
  input logic [AW-1:0] dram_base,
  input logic [AW-1:0] dram_lim,
  input logic [AW-1:0] cache_lim
);

  assert_reset_values_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (win_base == WIN_RST && dram_base == '0 && dram_lim == '0 && cache_lim == '0));

  assert_base_load_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_addr - win_base) == AW'(32'h0010_0000)) |=> dram_base == $past(wr_data));

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(win_base) && $stable(dram_base) && $stable(dram_lim) && $stable(cache_lim)));

  assert_win_move_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_addr - win_base) == AW'(32'h0010_0400)) |=> win_base[20:0] == '0);

  assert_cache_range_R5: assert property (@(posedge clk) disable iff (rst)
    hit_class == 2'b10 |-> (req_addr >= dram_base && req_addr < cache_lim));

  assert_reg_priority_R6: assert property (@(posedge clk) disable iff (rst)
    hit_class[1] |-> (req_addr - win_base) >= AW'(32'h0020_0000));

  assert_gran_flag_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_addr - win_base) == AW'(32'h0010_0004) && wr_data[15:0] != '0) |=> cfg_err);

  assert_order_flag_R9: assert property (@(posedge clk) disable iff (rst)
    (cache_lim > dram_lim) |-> cfg_err);

endmodule

bind aperture_classifier apc_checker #(.AW(ADDR_W), .WIN_RST(MMIO_RESET)) u_apc_checker (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .req_addr  (req_addr),
  .hit_class (hit_class),
  .cfg_err   (cfg_err),
  .win_base  (win_base),
  .dram_base (dram_base),
  .dram_lim  (dram_lim),
  .cache_lim (cache_lim)
);

// File: tb/test_aperture_classifier.sv
`timescale 1ns/1ps
module test_aperture_classifier;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] req_addr = '0;
  logic [1:0]  hit_class;
  logic [20:0] reg_offset;
  logic        cfg_err;

  int checks = 0;
  int errors = 0;

  // behavioural model state
  logic [31:0] m_win, m_base, m_lim, m_cache;

  always #2 clk = ~clk;

  aperture_classifier i_aperture_classifier (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .req_addr(req_addr), .hit_class(hit_class), .reg_offset(reg_offset), .cfg_err(cfg_err)
  );

  function automatic void model_reset();
    m_win = 32'hEFE0_0000; m_base = '0; m_lim = '0; m_cache = '0;
  endfunction

  function automatic logic [1:0] exp_class(input logic [31:0] a);
    longint unsigned rel = longint'(a) - longint'(m_win);
    if (a >= m_win && rel < 64'h20_0000) return 2'b01;
    if (a >= m_base && a < m_lim) return (a < m_cache) ? 2'b10 : 2'b11;
    return 2'b00;
  endfunction

  function automatic logic exp_err();
    longint unsigned span, p;
    logic e = 1'b0;
    if (m_lim % 65536 != 0 || m_cache % 65536 != 0) e = 1'b1;
    if (m_cache > m_lim) e = 1'b1;
    if (m_lim > m_base) begin
      span = longint'(m_lim) - longint'(m_base);
      p = 1;
      while (p < span) p = p * 2;
      if (longint'(m_base) % p != 0) e = 1'b1;
    end
    return e;
  endfunction

  task automatic cyc(input bit we, input logic [31:0] wa, input logic [31:0] wd,
                     input logic [31:0] ra, input string tag);
    logic [1:0]  ec;
    logic [20:0] eo;
    logic        ee;
    logic [31:0] rel;
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_data = wd; req_addr = ra;
    #1;
    ec = exp_class(ra);
    eo = (ec == 2'b01) ? 21'(ra - m_win) : 21'd0;
    ee = exp_err();
    checks++;
    if (hit_class !== ec || reg_offset !== eo || cfg_err !== ee) begin
      errors++;
      $display("FAIL %s addr=%h: class=%b off=%h err=%b expected class=%b off=%h err=%b",
               tag, ra, hit_class, reg_offset, cfg_err, ec, eo, ee);
    end
    @(posedge clk);
    if (we) begin
      rel = wa - m_win;
      case (rel)
        32'h0010_0400: m_win   = {wd[31:21], 21'd0};
        32'h0010_0000: m_base  = wd;
        32'h0010_0004: m_lim   = wd;
        32'h0010_0008: m_cache = wd;
        default: ;
      endcase
    end
  endtask

  task automatic probe(input logic [31:0] ra, input string tag);
    cyc(1'b0, 32'h0, 32'h0, ra, tag);
  endtask

  task automatic wr(input logic [31:0] wa, input logic [31:0] wd, input string tag);
    cyc(1'b1, wa, wd, wa, tag);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; wr_en = 1'b0;
    @(posedge clk); @(posedge clk);
    model_reset();
    @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // reset state
    probe(32'hEFF0_0400, "R1 R2");
    probe(32'h0000_0000, "R1 R7");
    probe(32'hEFE0_0000, "R1 R2");
    probe(32'hEFDF_FFFF, "R7");
    probe(32'hF000_0000, "R7");

    // program a 6 MB DRAM window at 0 with a 4 MB cacheable prefix
    wr(32'hEFF0_0000, 32'h0000_0000, "R3");
    wr(32'hEFF0_0004, 32'h0060_0000, "R3");
    wr(32'hEFF0_0008, 32'h0040_0000, "R3");
    probe(32'h0000_0000, "R5");
    probe(32'h003F_FFFF, "R5");
    probe(32'h0040_0000, "R5");
    probe(32'h005F_FFFF, "R5");
    probe(32'h0060_0000, "R7");
    probe(32'hEFE1_2345, "R2");

    // ignored writes: strobe low, unknown offset
    cyc(1'b0, 32'hEFF0_0004, 32'h0010_0000, 32'h005F_FFFF, "R3");
    wr(32'hEFF0_000C, 32'h0010_0000, "R3");
    probe(32'h005F_FFFF, "R3");

    // move the register window on top of DRAM
    wr(32'hEFF0_0400, 32'h0041_2345, "R4");
    probe(32'h0045_0000, "R4 R6");
    probe(32'h0040_0000, "R6");
    probe(32'h005F_FFFF, "R6");
    probe(32'h003F_FFFF, "R5");
    probe(32'hEFE1_2345, "R4 R7");
    wr(32'h0050_0004, 32'h0061_0000, "R4");
    probe(32'h0060_FFFF, "R4 R5");
    wr(32'hEFF0_0004, 32'h0000_0000, "R4");
    probe(32'h0060_FFFF, "R4");

    // granularity
    wr(32'h0050_0004, 32'h0061_0001, "R8");
    probe(32'h0, "R8");
    wr(32'h0050_0004, 32'h0061_0000, "R8");
    wr(32'h0050_0008, 32'h0040_0010, "R8");
    probe(32'h0, "R8");
    wr(32'h0050_0008, 32'h0040_0000, "R8");

    // ordering
    wr(32'h0050_0008, 32'h0070_0000, "R9");
    probe(32'h0, "R9");
    wr(32'h0050_0008, 32'h0061_0000, "R9");
    probe(32'h0061_0000, "R9");

    // move window away, then base alignment
    wr(32'h0050_0400, 32'hC000_0000, "R4");
    wr(32'hC010_0008, 32'h0000_0000, "R10");
    wr(32'hC010_0000, 32'h0040_0000, "R10");
    wr(32'hC010_0004, 32'h00A0_0000, "R10");
    probe(32'h0040_0000, "R10");
    wr(32'hC010_0000, 32'h0080_0000, "R10");
    wr(32'hC010_0004, 32'h00E0_0000, "R10");
    probe(32'h0080_0000, "R10");
    wr(32'hC010_0008, 32'h00C0_0000, "R10");
    probe(32'h0080_0000, "R5");
    probe(32'h00BF_FFFF, "R5");
    probe(32'h00C0_0000, "R5");
    probe(32'h00DF_FFFF, "R5");
    probe(32'h007F_FFFF, "R7");
    probe(32'h00E0_0000, "R7");
    wr(32'hC010_0004, 32'h0100_0000, "R10");
    probe(32'h00FF_FFFF, "R10");

    // boundary-heavy sweep
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a;
      case (i % 4)
        0: a = 32'h0080_0000 + ($urandom % 32'h0090_0000) - 32'h8_0000;
        1: a = 32'hC000_0000 + ($urandom % 32'h0030_0000) - 32'h8_0000;
        2: a = 32'h00C0_0000 + ($urandom % 16) - 8;
        default: a = $urandom;
      endcase
      probe(a, "R2 R5 R7");
    end

    // reset after configuration
    do_reset();
    probe(32'h0080_0000, "R1");
    probe(32'hEFF0_0400, "R1 R2");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule